// File: doc/BRIEF.md
# Sixteen-bit ISA subset executor

This block is a compact processor core that runs a subset of a 16-bit load/store instruction set. When its `step` input is high at a rising clock edge it executes exactly one instruction. It fetches the word at PC, decodes it, and updates the eight general registers, the PC and the negative/zero/positive condition flags. The supported instructions are: load effective address, load word, add with immediate, conditional branch, trap through a vector table, load byte and store byte.

Memory is byte-addressed and little-endian. The memory itself sits outside the core. The core reaches it through three ports, all read or written in the same cycle as the step:
- a combinational fetch port;
- a combinational data read port that returns the aligned word containing the addressed byte;
- a data write port with two byte-lane enables.

Two parameters choose independently, for the byte load and for the byte store, whether the data register field and the base register field sit in their standard positions or are exchanged. A read-only observation port shows any general register, so the architectural state can be watched.

Top module: `hx16_core`

## Requirements
- R1: While `rst` is high at a clock edge, PC takes `RESET_PC`, all eight registers become 0, the flags become Z (`flags_o` = 3'b010, bit order {N,Z,P}), and `halted` clears.
- R2: Opcode 4'b1110 writes PC+2 + (sign-extended bits 8:0 shifted left by one) into the register in bits 11:9 and sets the flags from that value.
- R3: Opcode 4'b0001 with bit 5 set writes reg[bits 8:6] + sign-extended bits 4:0 into reg[bits 11:9] and sets the flags.
- R4: Opcode 4'b0110 loads the word at reg[bits 8:6] + (sign-extended bits 5:0 shifted left by one) into reg[bits 11:9] and sets the flags. The word at even address A is {byte A+1, byte A}.
- R5: Opcode 4'b0000 jumps to PC+2 + (sign-extended bits 8:0 shifted left by one) when any of bits 11,10,9 is set together with the current N,Z,P flag respectively. Otherwise PC becomes PC+2, and a mask of 000 never branches.
- R6: Opcode 4'b1111 with bits 11:8 zero writes PC+2 into R7 and loads PC from the word at {bits 7:0, 1'b0}. When bits 7:0 equal `HALT_VEC`, `halted` rises, and later steps change nothing until reset.
- R7: Opcode 4'b0010 loads the byte at base + sign-extended bits 5:0 (unscaled), sign-extends it to 16 bits, writes the data register and sets the flags. Address bit 0 set selects the high byte of the word.
- R8: Opcode 4'b0011 writes bits 7:0 of the data register to the byte at base + sign-extended bits 5:0 (unscaled), enabling only lane 1 (odd address) or lane 0 (even address). It leaves the other byte and the flags untouched.
- R9: With the swap parameter of a byte opcode at 0, its data register is in bits 11:9 and its base in bits 8:6. At 1 these two fields are exchanged. `LDB_SWAP` and `STB_SWAP` act independently.
- R10: `illegal` is high whenever the fetched word is outside the subset: another opcode, 4'b0001 with bit 5 clear, or 4'b1111 with bits 11:8 nonzero. Stepping such a word changes no PC, register or flag.
- R11: After any flag-setting instruction exactly one flag is set, matching the sign and zero-ness of the value written.
- R12: The program E005, 6200, 127F, 0401, 0FFD, F025 at 0x3000 with data 0x000A after it counts R1 from 10 down to 0 and halts on the trap with vector 0x25.
- R13: With `step` low, PC, flags and registers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Execute one instruction at this edge |
| fetch_addr | output | 16 | Address of the instruction word (PC) |
| fetch_data | input | 16 | Instruction word at `fetch_addr` |
| rd_addr | output | 16 | Data read byte address |
| rd_data | input | 16 | Aligned word containing `rd_addr` |
| wr_en | output | 1 | Byte store this cycle |
| wr_addr | output | 16 | Store byte address |
| wr_data | output | 16 | Store byte replicated on both lanes |
| wr_be | output | 2 | Lane enables, bit 1 = odd byte |
| peek_sel | input | 3 | Register selected for observation |
| peek_data | output | 16 | Value of the selected register |
| pc_o | output | 16 | Current PC |
| flags_o | output | 3 | Flags {N,Z,P} |
| halted | output | 1 | Halt trap taken |
| illegal | output | 1 | Fetched word is outside the subset |

## Verification
The bench builds the core with `RESET_PC` = 0x3000, `LDB_SWAP` = 1 and `STB_SWAP` = 0. With these values one run covers both the exchanged field layout for the byte load and the standard layout for the byte store, so the independence of the two swap settings can be checked. The starting address lets the counting program run unchanged. Further programs loaded after a reset cover byte lanes at odd and even addresses, negative offsets, every branch mask outcome, a non-halting trap followed by a halting one, and each kind of illegal word.

// File: rtl/hx16_pkg.sv
`timescale 1ns/1ps
package hx16_pkg;
    localparam int unsigned XLEN = 16;
    localparam int unsigned NREG = 8;
    localparam int unsigned RW   = $clog2(NREG);

    localparam logic [3:0] OPC_BR   = 4'b0000;
    localparam logic [3:0] OPC_ADD  = 4'b0001;
    localparam logic [3:0] OPC_LDB  = 4'b0010;
    localparam logic [3:0] OPC_STB  = 4'b0011;
    localparam logic [3:0] OPC_LDW  = 4'b0110;
    localparam logic [3:0] OPC_LEA  = 4'b1110;
    localparam logic [3:0] OPC_TRAP = 4'b1111;

    typedef enum logic [2:0] {
        K_BR, K_ADD, K_LDB, K_STB, K_LDW, K_LEA, K_TRAP, K_BAD
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [RW-1:0]     dst;   // written register
        logic [RW-1:0]     sa;    // base / first source
        logic [RW-1:0]     sb;    // store data source
        logic [2:0]        nzp;   // branch mask
        logic [XLEN-1:0]   offs;  // final extended, scaled offset
        logic [7:0]        vec;   // trap vector
    } dec_t;

    typedef struct packed {
        logic              en;
        logic [RW-1:0]     sel;
        logic [XLEN-1:0]   val;
    } wb_t;

    function automatic logic [XLEN-1:0] sx9(input logic [8:0] v);
        return {{(XLEN-9){v[8]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] sx8(input logic [7:0] v);
        return {{(XLEN-8){v[7]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] sx6(input logic [5:0] v);
        return {{(XLEN-6){v[5]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] sx5(input logic [4:0] v);
        return {{(XLEN-5){v[4]}}, v};
    endfunction

    // {N,Z,P} from a written value
    function automatic logic [2:0] cc_of(input logic [XLEN-1:0] v);
        logic zero;
        zero = (v == '0);
        return {v[XLEN-1], zero, ~v[XLEN-1] & ~zero};
    endfunction
endpackage

// File: rtl/hx16_decode.sv
`timescale 1ns/1ps
module hx16_decode
    import hx16_pkg::*;
#(
    parameter bit LDB_SWAP = 1'b0,
    parameter bit STB_SWAP = 1'b0
) (
    input  logic [XLEN-1:0] instr,
    output dec_t            dk
);
    logic [RW-1:0] lb_data, lb_base, sb_data, sb_base;

    generate
        if (LDB_SWAP) begin : g_ldb_swapped
            assign lb_data = instr[8:6];
            assign lb_base = instr[11:9];
        end else begin : g_ldb_std
            assign lb_data = instr[11:9];
            assign lb_base = instr[8:6];
        end
        if (STB_SWAP) begin : g_stb_swapped
            assign sb_data = instr[8:6];
            assign sb_base = instr[11:9];
        end else begin : g_stb_std
            assign sb_data = instr[11:9];
            assign sb_base = instr[8:6];
        end
    endgenerate

    always_comb begin
        dk      = '0;
        dk.kind = K_BAD;
        dk.dst  = instr[11:9];
        dk.sa   = instr[8:6];
        dk.sb   = instr[11:9];
        dk.nzp  = instr[11:9];
        dk.vec  = instr[7:0];
        unique case (instr[15:12])
            OPC_BR: begin
                dk.kind = K_BR;
                dk.offs = sx9(instr[8:0]) << 1;
            end
            OPC_ADD: begin
                if (instr[5]) dk.kind = K_ADD;
                dk.offs = sx5(instr[4:0]);
            end
            OPC_LDW: begin
                dk.kind = K_LDW;
                dk.offs = sx6(instr[5:0]) << 1;
            end
            OPC_LEA: begin
                dk.kind = K_LEA;
                dk.offs = sx9(instr[8:0]) << 1;
            end
            OPC_TRAP: begin
                if (instr[11:8] == 4'h0) dk.kind = K_TRAP;
                dk.offs = {{(XLEN-9){1'b0}}, instr[7:0], 1'b0};
            end
            OPC_LDB: begin
                dk.kind = K_LDB;
                dk.dst  = lb_data;
                dk.sa   = lb_base;
                dk.offs = sx6(instr[5:0]);
            end
            OPC_STB: begin
                dk.kind = K_STB;
                dk.sb   = sb_data;
                dk.sa   = sb_base;
                dk.offs = sx6(instr[5:0]);
            end
            default: dk.kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/hx16_regfile.sv
`timescale 1ns/1ps
module hx16_regfile
    import hx16_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [RW-1:0]   wsel,
    input  logic [XLEN-1:0] wdata,
    input  logic [RW-1:0]   ra_sel,
    output logic [XLEN-1:0] ra_data,
    input  logic [RW-1:0]   rb_sel,
    output logic [XLEN-1:0] rb_data,
    input  logic [RW-1:0]   rp_sel,
    output logic [XLEN-1:0] rp_data
);
    logic [XLEN-1:0] rview [NREG];

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            logic [XLEN-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)                          q <= '0;
                else if (we && wsel == RW'(g))    q <= wdata;
            end
            assign rview[g] = q;
        end
    endgenerate

    assign ra_data = rview[ra_sel];
    assign rb_data = rview[rb_sel];
    assign rp_data = rview[rp_sel];
endmodule

// File: rtl/hx16_core.sv
`timescale 1ns/1ps
module hx16_core
    import hx16_pkg::*;
#(
    parameter logic [15:0] RESET_PC = 16'h3000,
    parameter bit          LDB_SWAP = 1'b0,
    parameter bit          STB_SWAP = 1'b0,
    parameter logic [7:0]  HALT_VEC = 8'h25
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        step,
    output logic [15:0] fetch_addr,
    input  logic [15:0] fetch_data,
    output logic [15:0] rd_addr,
    input  logic [15:0] rd_data,
    output logic        wr_en,
    output logic [15:0] wr_addr,
    output logic [15:0] wr_data,
    output logic [1:0]  wr_be,
    input  logic [2:0]  peek_sel,
    output logic [15:0] peek_data,
    output logic [15:0] pc_o,
    output logic [2:0]  flags_o,
    output logic        halted,
    output logic        illegal
);
    logic [XLEN-1:0] pc_q, pc_inc, pc_nx, ea, tgt, va, vb;
    logic [2:0]      flags_q;
    logic            halt_q, go, set_cc;
    logic [7:0]      byte_pick;
    dec_t            dk;
    wb_t             wb;

    hx16_decode #(.LDB_SWAP(LDB_SWAP), .STB_SWAP(STB_SWAP)) u_dec (
        .instr (fetch_data),
        .dk    (dk)
    );

    hx16_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (go && wb.en),
        .wsel    (wb.sel),
        .wdata   (wb.val),
        .ra_sel  (dk.sa),
        .ra_data (va),
        .rb_sel  (dk.sb),
        .rb_data (vb),
        .rp_sel  (peek_sel),
        .rp_data (peek_data)
    );

    assign pc_inc    = pc_q + XLEN'(2);
    assign ea        = va + dk.offs;
    assign tgt       = pc_inc + dk.offs;
    assign byte_pick = ea[0] ? rd_data[15:8] : rd_data[7:0];
    assign go        = step && !halt_q && (dk.kind != K_BAD);

    always_comb begin
        wb     = '0;
        wb.sel = dk.dst;
        set_cc = 1'b0;
        pc_nx  = pc_inc;
        case (dk.kind)
            K_ADD:  begin wb.en = 1'b1; wb.val = ea;            set_cc = 1'b1; end
            K_LEA:  begin wb.en = 1'b1; wb.val = tgt;           set_cc = 1'b1; end
            K_LDW:  begin wb.en = 1'b1; wb.val = rd_data;       set_cc = 1'b1; end
            K_LDB:  begin wb.en = 1'b1; wb.val = sx8(byte_pick); set_cc = 1'b1; end
            K_BR:   if (|(dk.nzp & flags_q)) pc_nx = tgt;
            K_TRAP: begin
                wb.en  = 1'b1;
                wb.sel = RW'(NREG - 1);
                wb.val = pc_inc;
                pc_nx  = rd_data;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= RESET_PC;
            flags_q <= 3'b010;
            halt_q  <= 1'b0;
        end else if (go) begin
            pc_q <= pc_nx;
            if (set_cc) flags_q <= cc_of(wb.val);
            if (dk.kind == K_TRAP && dk.vec == HALT_VEC) halt_q <= 1'b1;
        end
    end

    assign fetch_addr = pc_q;
    assign rd_addr    = (dk.kind == K_TRAP) ? dk.offs : ea;
    assign wr_en      = go && (dk.kind == K_STB);
    assign wr_addr    = ea;
    assign wr_data    = {vb[7:0], vb[7:0]};
    assign wr_be      = ea[0] ? 2'b10 : 2'b01;
    assign pc_o       = pc_q;
    assign flags_o    = flags_q;
    assign halted     = halt_q;
    assign illegal    = (dk.kind == K_BAD);

    // R11
    flags_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(flags_q) == 1);

    // R6
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        halt_q |=> (halt_q && $stable(pc_q) && $stable(flags_q)));

    // R10
    illegal_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (step && illegal) |=> ($stable(pc_q) && $stable(flags_q)));

    // R8
    store_cc_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> $stable(flags_q));

    // R13
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> ($stable(pc_q) && $stable(flags_q) && $stable(halt_q)));
endmodule

// File: tb/hx16_core_tb.sv
`timescale 1ns/1ps
module hx16_core_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step = 1'b0;
    logic [15:0] fetch_addr, fetch_data, rd_addr, rd_data;
    logic        wr_en;
    logic [15:0] wr_addr, wr_data;
    logic [1:0]  wr_be;
    logic [2:0]  peek_sel = 3'd0;
    logic [15:0] peek_data, pc_o;
    logic [2:0]  flags_o;
    logic        halted, illegal;

    logic [7:0] mem [0:65535];
    int n_run = 0, n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        string       req;
        logic [15:0] pc;
        logic [2:0]  flg;
        int          rsel;
        logic [15:0] rval;
    } exp_t;
    exp_t q[$];
    event mon_ev;

    always #2 clk = ~clk;

    hx16_core #(.RESET_PC(16'h3000), .LDB_SWAP(1'b1), .STB_SWAP(1'b0), .HALT_VEC(8'h25)) u_dut (
        .clk(clk), .rst(rst), .step(step),
        .fetch_addr(fetch_addr), .fetch_data(fetch_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .peek_sel(peek_sel), .peek_data(peek_data),
        .pc_o(pc_o), .flags_o(flags_o), .halted(halted), .illegal(illegal)
    );

    assign fetch_data = {mem[{fetch_addr[15:1], 1'b1}], mem[{fetch_addr[15:1], 1'b0}]};
    assign rd_data    = {mem[{rd_addr[15:1], 1'b1}], mem[{rd_addr[15:1], 1'b0}]};

    always @(posedge clk) begin
        if (wr_en) begin
            if (wr_be[0]) mem[{wr_addr[15:1], 1'b0}] = wr_data[7:0];
            if (wr_be[1]) mem[{wr_addr[15:1], 1'b1}] = wr_data[15:8];
        end
    end

    function automatic void chk(string req, string what, logic [15:0] act, logic [15:0] expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endfunction

    task automatic put_word(input logic [15:0] a, input logic [15:0] w);
        mem[{a[15:1], 1'b0}] = w[7:0];
        mem[{a[15:1], 1'b1}] = w[15:8];
    endtask

    // driver: one step, then hand the expectation to the monitor
    task automatic do_step(input string req, input logic [15:0] epc, input logic [2:0] ef,
                           input int rs, input logic [15:0] rv);
        exp_t it;
        @(negedge clk) step = 1'b1;
        @(negedge clk) step = 1'b0;
        it.req = req; it.pc = epc; it.flg = ef; it.rsel = rs; it.rval = rv;
        q.push_back(it);
        -> mon_ev;
    endtask

    task automatic expect_now(input string req, input logic [15:0] epc, input logic [2:0] ef,
                              input int rs, input logic [15:0] rv);
        exp_t it;
        it.req = req; it.pc = epc; it.flg = ef; it.rsel = rs; it.rval = rv;
        q.push_back(it);
        -> mon_ev;
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    // monitor: pops expectations and compares with the outputs
    initial begin
        exp_t it;
        forever begin
            @(mon_ev);
            #0.5;
            while (q.size() > 0) begin
                it = q.pop_front();
                chk(it.req, "pc", pc_o, it.pc);
                chk(it.req, "flags", {13'd0, flags_o}, {13'd0, it.flg});
                if (it.rsel >= 0) begin
                    peek_sel = it.rsel[2:0];
                    #0.1;
                    chk(it.req, $sformatf("r%0d", it.rsel), peek_data, it.rval);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R12 watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 65536; a++) mem[a] = 8'h00;
        // counting program
        put_word(16'h3000, 16'hE005);
        put_word(16'h3002, 16'h6200);
        put_word(16'h3004, 16'h127F);
        put_word(16'h3006, 16'h0401);
        put_word(16'h3008, 16'h0FFD);
        put_word(16'h300A, 16'hF025);
        put_word(16'h300C, 16'h000A);
        put_word(16'h004A, 16'h0200);

        do_reset();
        #1;
        // R1 reset state
        chk("R1", "halted", {15'd0, halted}, 16'd0);
        chk("R10", "illegal", {15'd0, illegal}, 16'd0);
        for (int r = 0; r < 8; r++) expect_now("R1", 16'h3000, 3'b010, r, 16'h0000);
        settle();

        do_step("R2", 16'h3002, 3'b001, 0, 16'h300C);
        do_step("R4", 16'h3004, 3'b001, 1, 16'h000A);
        for (int i = 9; i >= 1; i--) begin
            do_step("R3", 16'h3006, 3'b001, 1, 16'(i));
            do_step("R5", 16'h3008, 3'b001, 1, 16'(i));
            do_step("R5", 16'h3004, 3'b001, 1, 16'(i));
        end
        do_step("R11", 16'h3006, 3'b010, 1, 16'h0000);
        do_step("R5", 16'h300A, 3'b010, -1, 16'h0000);
        do_step("R12", 16'h0200, 3'b010, 7, 16'h300C);
        settle();
        chk("R12", "halted", {15'd0, halted}, 16'd1);
        do_step("R6", 16'h0200, 3'b010, 7, 16'h300C);
        settle();
        chk("R6", "halted after step", {15'd0, halted}, 16'd1);

        // second program: byte ops, branches, illegal
        put_word(16'h3000, 16'h143F);
        put_word(16'h3002, 16'hE61E);
        put_word(16'h3004, 16'h2701);
        put_word(16'h3006, 16'h2740);
        put_word(16'h3008, 16'h34C3);
        put_word(16'h300A, 16'h3AFE);
        put_word(16'h300C, 16'h6CFF);
        put_word(16'h300E, 16'h1020);
        put_word(16'h3010, 16'h0A05);
        put_word(16'h3012, 16'h0404);
        put_word(16'h301C, 16'h12AF);
        put_word(16'h301E, 16'h0003);
        put_word(16'h3020, 16'hD000);
        put_word(16'h3040, 16'h857F);
        put_word(16'h3042, 16'h3311);
        put_word(16'h303E, 16'h2200);

        do_reset();
        #1;
        chk("R1", "halted cleared", {15'd0, halted}, 16'd0);
        expect_now("R1", 16'h3000, 3'b010, 1, 16'h0000);
        settle();
        do_step("R3", 16'h3002, 3'b100, 2, 16'hFFFF);
        repeat (3) @(negedge clk);
        expect_now("R13", 16'h3002, 3'b100, 2, 16'hFFFF);
        settle();
        do_step("R2", 16'h3004, 3'b001, 3, 16'h3040);
        // LDB swapped fields: base R3 in 11:9, dest R4 in 8:6, odd address -> high byte
        do_step("R9", 16'h3006, 3'b100, 4, 16'hFF85);
        do_step("R7", 16'h3008, 3'b001, 5, 16'h007F);
        // STB standard fields: data R2, base R3, odd address 0x3043
        do_step("R8", 16'h300A, 3'b001, 2, 16'hFFFF);
        do_step("R8", 16'h300C, 3'b001, 5, 16'h007F);
        settle();
        chk("R8", "byte 3043", {8'd0, mem[16'h3043]}, 16'h00FF);
        chk("R8", "byte 3042", {8'd0, mem[16'h3042]}, 16'h0011);
        chk("R8", "byte 303E", {8'd0, mem[16'h303E]}, 16'h007F);
        chk("R9", "byte 303F", {8'd0, mem[16'h303F]}, 16'h0022);
        do_step("R4", 16'h300E, 3'b001, 6, 16'h227F);
        do_step("R11", 16'h3010, 3'b010, 0, 16'h0000);
        do_step("R5", 16'h3012, 3'b010, -1, 16'h0000);
        do_step("R5", 16'h301C, 3'b010, -1, 16'h0000);
        do_step("R3", 16'h301E, 3'b001, 1, 16'h000E);
        do_step("R5", 16'h3020, 3'b001, -1, 16'h0000);
        settle();
        chk("R10", "illegal opcode", {15'd0, illegal}, 16'd1);
        do_step("R10", 16'h3020, 3'b001, 1, 16'h000E);
        settle();

        // third program: illegal forms, traps
        put_word(16'h3000, 16'h1042);
        put_word(16'h0020, 16'h0400);
        put_word(16'h0400, 16'hF025);
        do_reset();
        #1;
        chk("R10", "illegal add form", {15'd0, illegal}, 16'd1);
        do_step("R10", 16'h3000, 3'b010, 1, 16'h0000);
        settle();
        put_word(16'h3000, 16'hF125);
        #1;
        chk("R10", "illegal trap form", {15'd0, illegal}, 16'd1);
        do_step("R10", 16'h3000, 3'b010, 7, 16'h0000);
        settle();
        chk("R6", "no halt on bad trap", {15'd0, halted}, 16'd0);
        put_word(16'h3000, 16'hF010);
        #1;
        chk("R10", "legal trap", {15'd0, illegal}, 16'd0);
        do_step("R6", 16'h0400, 3'b010, 7, 16'h3002);
        settle();
        chk("R6", "no halt vec 10", {15'd0, halted}, 16'd0);
        do_step("R6", 16'h0200, 3'b010, 7, 16'h0402);
        settle();
        chk("R6", "halt vec 25", {15'd0, halted}, 16'd1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule